// File: doc/BRIEF.md
# Pipelined Burst SRAM Model

A cycle-level, synthesizable model of a pipelined synchronous SRAM that needs no idle cycles when reads and writes alternate. It samples a command on every rising clock edge at which the active-low clock enable is asserted. The command carries the three chip selects, an advance/load flag, write enable, per-lane write strobes and an address. A load starts a new single or burst access. Each continuation steps a 2-bit burst counter over the low address bits, in linear or interleaved order, and the order is chosen by a static strap input.

The data bus is modelled as separate input, output and output-enable signals. Read data is registered after the first enabled edge that follows the address edge. The host takes it at the second enabled edge. Write data is taken from the input bus at the second enabled edge after its address. This spacing keeps the two bus phases of back-to-back read and write beats from overlapping. The bus is released during write-data cycles, during the first cycle after a deselect, and while deselected, whatever the output enable says.

Top module: `sbsram`

## Requirements
- R1: While cken_ni is high, a clock edge changes no state: dq_o and the data-held flag behind dq_oe_o keep their values, and the edge counts as no pipeline step.
- R2: A load (adv_i low) selects the device only when cs1_ni is 0, cs2_i is 1 and cs3_ni is 0 at that edge. Otherwise the beat is a deselect that neither reads nor writes.
- R3: A selected load takes addr_i as the beat address. The beat is a write when we_ni is 0 and a read when we_ni is 1.
- R4: For a read beat at enabled edge E0, the word is held on dq_o from enabled edge E1 until the next enabled edge, so the host takes it at E2.
- R5: For a write beat at E0, the memory takes dq_i at enabled edge E2. Lane k is dq bits [9k+8:9k], 8 data bits plus a parity bit in bit 9k+8. It is written only if bw_ni[k] was 0 at E0.
- R6: With order_i = 0, continuation beat n of a burst addresses the start address with its two low bits replaced by (start + n) mod 4. The upper bits are kept.
- R7: With order_i = 1, continuation beat n uses low bits (start XOR n).
- R8: A continuation (adv_i high) repeats the read or write type of the loaded access, whatever we_ni and the chip selects say. Its own bw_ni is used for its lanes.
- R9: A continuation that arrives while the device is deselected leaves it deselected.
- R10: dq_oe_o is 1 only when oe_ni is 0 and dq_o holds a read beat. It is 0 in write-data cycles, in the first cycle after a deselect and while deselected.
- R11: A read whose data is registered at the same edge at which a write to the same address commits returns the newly written lanes.
- R12: After reset, dq_oe_o is 0, dq_o is 0 and every memory word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cken_ni | input | 1 | Clock enable, active low |
| cs1_ni | input | 1 | Chip select 1, active low |
| cs2_i | input | 1 | Chip select 2, active high |
| cs3_ni | input | 1 | Chip select 3, active low |
| adv_i | input | 1 | 1 = continue burst, 0 = load address |
| we_ni | input | 1 | Write enable for a load, active low |
| bw_ni | input | LANES | Per-lane write strobes, active low |
| addr_i | input | ADDR_W | Word address |
| order_i | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| oe_ni | input | 1 | Output enable, active low |
| dq_i | input | LANES*LANE_W | Write data bus |
| dq_o | output | LANES*LANE_W | Read data bus |
| dq_oe_o | output | 1 | Read bus drive enable |

## Verification
Two functions can meet in one cycle. A read can register its data at the same edge at which an earlier write to the same word commits, and a clock-enable stall can land in the middle of a burst that switches between read and write. The bench provokes the first with a phase of strictly alternating write and read loads over eight addresses, so that a read beat follows a write beat to the same word at one-edge spacing. It provokes the second with random stalls across long bursts in both orders. A bench model that keeps its own beat history judges every cycle. It predicts dq_o from its own array after applying the committing write's masked lanes first, and it predicts dq_oe_o from oe_ni and the read-beat history.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;

  localparam int BURST_W = 2;
endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] beat_addr_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [BURST_W-1:0] base_q, base_n, cnt_q, cnt_n, low;
  logic [HI_W-1:0]    hi_q, hi_n;

  always_comb begin
    if (load_i) begin
      base_n = addr_i[BURST_W-1:0];
      hi_n   = addr_i[ADDR_W-1:BURST_W];
      cnt_n  = '0;
    end else begin
      base_n = base_q;
      hi_n   = hi_q;
      cnt_n  = cnt_q + 1'b1;
    end
  end

  // order variant picked by the strap
  always_comb begin
    if (order_i) low = base_n ^ cnt_n;
    else         low = base_n + cnt_n;
  end

  assign beat_addr_o = {hi_n, low};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      hi_q   <= '0;
      cnt_q  <= '0;
    end else if (en_i && (load_i || adv_i)) begin
      base_q <= base_n;
      hi_q   <= hi_n;
      cnt_q  <= cnt_n;
    end
  end

  assert_cnt_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> (cnt_q == '0 && base_q == $past(addr_i[BURST_W-1:0])));
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cs1_ni,
  input  logic              cs2_i,
  input  logic              cs3_ni,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] beat_addr_i,
  output logic              load_o,
  output acc_e              s1_kind_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LANES-1:0]  wr_bw_o
);
  acc_e              s1_kind_q, s2_kind_q, kind_n;
  logic [ADDR_W-1:0] s1_addr_q, s2_addr_q;
  logic [LANES-1:0]  s1_bw_q, s2_bw_q;
  logic              sel;

  assign sel    = !cs1_ni && cs2_i && !cs3_ni;
  assign load_o = !adv_i && sel;

  always_comb begin
    if (!adv_i)      kind_n = !sel ? ACC_IDLE : (we_ni ? ACC_RD : ACC_WR);
    else             kind_n = s1_kind_q;  // continuation repeats type, idle stays idle
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_kind_q <= ACC_IDLE;
      s1_addr_q <= '0;
      s1_bw_q   <= '1;
      s2_kind_q <= ACC_IDLE;
      s2_addr_q <= '0;
      s2_bw_q   <= '1;
    end else if (en_i) begin
      s1_kind_q <= kind_n;
      s1_addr_q <= beat_addr_i;
      s1_bw_q   <= bw_ni;
      s2_kind_q <= s1_kind_q;
      s2_addr_q <= s1_addr_q;
      s2_bw_q   <= s1_bw_q;
    end
  end

  assign s1_kind_o = s1_kind_q;
  assign s1_addr_o = s1_addr_q;
  assign rd_req_o  = en_i && (s1_kind_q == ACC_RD);
  assign wr_req_o  = en_i && (s2_kind_q == ACC_WR);
  assign wr_addr_o = s2_addr_q;
  assign wr_bw_o   = s2_bw_q;

  assert_desel_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !adv_i && (cs1_ni || !cs2_i || cs3_ni)) |=> (s1_kind_q == ACC_IDLE));

  assert_desel_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && s1_kind_q == ACC_IDLE) |=> (s1_kind_q == ACC_IDLE));

  assert_cont_type_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i) |=> (s1_kind_q == $past(s1_kind_q)));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_req_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES-1:0]        wr_bw_ni,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_data_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              hit;

  assign hit = wr_req_i && (wr_addr_i == rd_addr_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) mem_q[w][k*LANE_W +: LANE_W] <= '0;
      end else if (wr_req_i && !wr_bw_ni[k]) begin
        mem_q[wr_addr_i][k*LANE_W +: LANE_W] <= wr_data_i[k*LANE_W +: LANE_W];
      end
    end

    // forward a lane committing at this same edge
    always_comb begin
      if (hit && !wr_bw_ni[k]) rd_data_o[k*LANE_W +: LANE_W] = wr_data_i[k*LANE_W +: LANE_W];
      else                     rd_data_o[k*LANE_W +: LANE_W] = mem_q[rd_addr_i][k*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/sbsram.sv
module sbsram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cken_ni,
  input  logic                    cs1_ni,
  input  logic                    cs2_i,
  input  logic                    cs3_ni,
  input  logic                    adv_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    order_i,
  input  logic                    oe_ni,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              en, load, rd_req, wr_req, rd_vld_q;
  logic [ADDR_W-1:0] beat_addr, s1_addr, wr_addr;
  logic [LANES-1:0]  wr_bw;
  logic [DATA_W-1:0] rd_word, dout_q;
  acc_e              s1_kind;

  assign en = !cken_ni;

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i, .rst_ni, .en_i(en), .load_i(load), .adv_i,
    .order_i, .addr_i, .beat_addr_o(beat_addr)
  );

  sbsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .en_i(en), .cs1_ni, .cs2_i, .cs3_ni, .adv_i, .we_ni,
    .bw_ni, .beat_addr_i(beat_addr), .load_o(load), .s1_kind_o(s1_kind),
    .s1_addr_o(s1_addr), .rd_req_o(rd_req), .wr_req_o(wr_req),
    .wr_addr_o(wr_addr), .wr_bw_o(wr_bw)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni, .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_bw_ni(wr_bw),
    .wr_data_i(dq_i), .rd_addr_i(s1_addr), .rd_data_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      dout_q   <= '0;
    end else if (en) begin
      rd_vld_q <= rd_req;
      if (rd_req) dout_q <= rd_word;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = rd_vld_q && !oe_ni;

  assert_stall_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cken_ni |=> ($stable(dout_q) && $stable(rd_vld_q)));

  assert_wr_phase_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req |-> !dq_oe_o);

  assert_linear_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && adv_i && !order_i && s1_kind != ACC_IDLE) |=>
      (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1 &&
       s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  assert_interleave_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && adv_i && order_i && s1_kind != ACC_IDLE) |=>
      (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]) &&
       s1_addr[1:0] != $past(s1_addr[1:0])));
endmodule

// File: tb/sbsram_bench.sv
module sbsram_bench;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0, cken_n = 1'b0, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic          adv = 1'b0, we_n = 1'b1, order = 1'b0, oe_n = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  sbsram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_sbsram (
    .clk_i(clk), .rst_ni(rst_n), .cken_ni(cken_n), .cs1_ni(cs1_n), .cs2_i(cs2),
    .cs3_ni(cs3_n), .adv_i(adv), .we_ni(we_n), .bw_ni(bw_n), .addr_i(addr),
    .order_i(order), .oe_ni(oe_n), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  int n_chk = 0, n_fail = 0;

  // bench model: 0 idle, 1 read, 2 write
  logic [DW-1:0] mdl [DEPTH];
  int            b1_kind, b2_kind, m_kind;
  logic [AW-1:0] b1_addr, b2_addr;
  logic [NL-1:0] b1_bw, b2_bw;
  logic          b1_cont;
  logic [1:0]    m_base, m_cnt;
  logic [AW-3:0] m_hi;
  logic          exp_rdv;
  logic [DW-1:0] exp_dq;
  string         rd_tag;

  function automatic logic [1:0] beat_low(logic [1:0] b, logic [1:0] c, logic ord);
    return ord ? (b ^ c) : (b + c);
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NL-1:0] m);
    logic [DW-1:0] r = old;
    for (int k = 0; k < NL; k++) if (!m[k]) r[k*LW +: LW] = nw[k*LW +: LW];
    return r;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < DEPTH; w++) mdl[w] = '0;
    b1_kind = 0; b2_kind = 0; m_kind = 0; b1_cont = 1'b0;
    b1_addr = '0; b2_addr = '0; b1_bw = '1; b2_bw = '1;
    m_base = '0; m_cnt = '0; m_hi = '0;
    exp_rdv = 1'b0; exp_dq = '0; rd_tag = "R4";
  endtask

  task automatic model_step();
    int            kind;
    logic          cont, sel, byp;
    logic [AW-1:0] ba;
    sel = !cs1_n && cs2 && !cs3_n;
    cont = adv;
    if (!adv) begin
      if (sel) begin
        kind = we_n ? 1 : 2;
        m_base = addr[1:0]; m_cnt = '0; m_hi = addr[AW-1:2];
      end else kind = 0;
    end else begin
      kind = m_kind;
      if (kind != 0) m_cnt = m_cnt + 2'd1;
    end
    ba = {m_hi, beat_low(m_base, m_cnt, order)};
    byp = 1'b0;
    if (b2_kind == 2) begin
      mdl[b2_addr] = merge(mdl[b2_addr], dq_in, b2_bw);
      byp = (b1_kind == 1) && (b1_addr == b2_addr) && (b2_bw != '1);
    end
    exp_rdv = (b1_kind == 1);
    if (exp_rdv) begin
      exp_dq = mdl[b1_addr];
      if (b1_cont) rd_tag = order ? "R7 R8 R5" : "R6 R8 R5";
      else         rd_tag = "R3 R4 R5";
      if (byp) rd_tag = {rd_tag, " R11"};
    end
    b2_kind = b1_kind; b2_addr = b1_addr; b2_bw = b1_bw;
    b1_kind = kind; b1_addr = ba; b1_bw = bw_n; b1_cont = cont;
    m_kind = kind;
  endtask

  task automatic do_reset(logic ord);
    rst_n = 1'b0; order = ord;
    cken_n = 1'b0; adv = 1'b0; cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; oe_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 dq_oe", {{(DW-1){1'b0}}, dq_oe}, '0);
    chk("R12 dq", dq_out, '0);
    rst_n = 1'b1;
  endtask

  // mode 0 random, 1 alternating write/read, 2 long bursts with stalls
  task automatic run(int mode, int cycles);
    for (int i = 0; i < cycles; i++) begin
      logic [DW-1:0] prev_dq;
      logic          prev_oe_int, stall;
      prev_dq = dq_out;
      prev_oe_int = exp_rdv;
      cken_n = ($urandom % 7) == 0;
      oe_n   = ($urandom % 8) == 0;
      dq_in  = {$urandom, $urandom};
      bw_n   = NL'($urandom);
      addr   = AW'($urandom);
      we_n   = $urandom % 2;
      adv    = ($urandom % 100) < 45;
      cs1_n  = ($urandom % 12) == 0;
      cs2    = ($urandom % 12) != 0;
      cs3_n  = ($urandom % 12) == 0;
      if (mode == 1) begin
        adv = 1'b0; cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        we_n = i[0];
        addr = AW'(i[3:1]);
        if (($urandom % 5) == 0) bw_n = '0;
      end else if (mode == 2) begin
        adv = (i % 4) != 0;
      end
      stall = cken_n;
      @(posedge clk);
      #1;
      if (!stall) model_step();
      #1;
      chk(stall ? "R1 R10 dq_oe" : "R2 R9 R10 dq_oe",
          {{(DW-1){1'b0}}, dq_oe}, {{(DW-1){1'b0}}, exp_rdv && !oe_n});
      if (stall) begin
        chk("R1 held dq", dq_out, prev_dq);
        chk("R1 held vld", {{(DW-1){1'b0}}, exp_rdv}, {{(DW-1){1'b0}}, prev_oe_int});
      end else if (exp_rdv) begin
        chk(rd_tag, dq_out, exp_dq);
      end
      @(negedge clk);
    end
  endtask

  bit done = 1'b0;

  initial begin
    void'($urandom(32'd20240917));
    model_reset();
    do_reset(1'b0);
    run(0, 1500);
    run(1, 300);
    run(2, 400);
    do_reset(1'b1);
    run(0, 1500);
    run(1, 300);
    run(2, 400);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule